// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck, typically with SDA held low in the middle of a byte. When the controller is about to begin a transfer, it raises a request. The block checks whether the bus is free, which means the controller is not busy and both SCL and SDA read high. If the bus is free, the block reports success at once and never touches the pins. If it is not free, the block takes over both open-drain lines. A recovery can also be forced with a separate timeout event, whatever the line state.

While it holds the lines, the block plays out a fixed pattern of 24 steps. It forms a start condition, then gives nine SCL pulses with SDA released, then forms a stop condition. Every step lasts a programmable dwell. The block then hands the pins back and sends a one-cycle state-reset pulse to the controller. After a short settle window it samples the lines again. It reports done, with fail set if either line is still low; in that case the pending transfer is to be dropped. A two-bit cause code records what triggered the most recent recovery.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, both drive-low outputs, the override flag, the controller-reset pulse, done and fail are all 0, and the cause code is 2'b00.
- R2: A request taken while busy is low and both synchronized lines are high produces done=1 with fail=0 in the next cycle, with no override and no line driven.
- R3: A request taken while busy is high, or while either synchronized line is low, starts a recovery: the override flag is high from the next cycle, and the cause code becomes 2'b01 (bus not idle).
- R4: A timeout event starts a recovery whatever the line state, and the cause code becomes 2'b10. The timeout takes precedence when a request arrives in the same cycle.
- R5: During the override, the pair (SCL low, SDA low) runs through 24 steps. Steps 0, 1 and 2 are (0,0), (0,1) and (1,1). Steps 3 to 20 alternate (0,0) and (1,0), starting with (0,0). Steps 21, 22 and 23 are (1,1), (0,1) and (0,0).
- R6: Each step lasts dwell+1 clock cycles. The dwell is taken from the dwell input in the cycle the recovery starts; dwell 0 gives one-cycle steps.
- R7: The outputs are open-drain controls: no line is driven low while the override flag is low.
- R8: The controller-reset pulse is high for exactly one cycle: the first cycle after the override flag drops.
- R9: Done rises SYNC_STAGES+1 cycles after the controller-reset pulse. Fail is set with it when the synchronized SCL or SDA is low at that point.
- R10: Requests, timeout events and dwell changes that arrive during a recovery are ignored: the pattern, its timing and the cause code are unchanged.
- R11: Done and fail are single-cycle pulses, and fail is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req_i | input | 1 | Transfer about to start; check the bus and recover if needed |
| timeout_evt_i | input | 1 | Transfer timed out; force a recovery |
| busy_i | input | 1 | Controller reports the bus as busy |
| dwell_i | input | DWELL_W | Dwell length; each step lasts dwell+1 cycles |
| scl_in_i | input | 1 | SCL line level |
| sda_in_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| ovr_o | output | 1 | Sequencer owns the pins |
| ctl_rst_o | output | 1 | One-cycle state reset to the controller |
| done_o | output | 1 | Check or recovery finished |
| fail_o | output | 1 | Bus still not idle; drop the transfer |
| cause_o | output | 2 | Trigger of the most recent recovery (01 not idle, 10 timeout) |

## Verification
Every result has a fixed due cycle, counted from the clock edge that takes the trigger. A fast-path done is due in the next cycle. The override is due in the next cycle, and step s is due in cycles s*(D+1) through s*(D+1)+D of the override. The controller reset is due at cycle 24*(D+1), and done and fail are due SYNC_STAGES+1 cycles after that. The bench counts cycles from the first override cycle and compares every cycle against these positions, sampling on the falling edge. Where a target holds SDA low, the bench releases it after a chosen number of SCL rising edges on the modelled wired-AND bus. Recovery is expected to pass when that number is at most ten, because the nine pulses plus the stop give ten rising edges.

// File: rtl/i2c_unstick_pkg.sv
// Shared types for the bus recovery sequencer.
package i2c_unstick_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_NOT_IDLE = 2'b01,
        CAUSE_TIMEOUT  = 2'b10
    } cause_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_SETTLE
    } phase_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } drive_t;
endpackage

// File: rtl/i2c_unstick_sync.sv
// Multi-stage synchronizer for the sampled bus lines.
// Assumes an idle bus (all ones) out of reset.
module i2c_unstick_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // capture the raw line levels
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '1;
                else        stg[0] <= d_i;
            end
        end else begin : g_next
            // shift toward the output
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '1;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_unstick_dwell.sv
// Step timer: latches the dwell on load and raises tick in the last
// cycle of every step, so each step lasts dwell+1 cycles.
module i2c_unstick_dwell #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dwell_i,
    input  logic         run_i,
    output logic         tick_o
);
    logic [W-1:0] dwell_q;
    logic [W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == dwell_q);

    // hold the dwell for the whole recovery and count cycles in a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            dwell_q <= dwell_i;
            cnt_q   <= '0;
        end else if (run_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_unstick_pattern.sv
// Decodes a step index into the pair of drive-low controls.
// The start steps, the clock pulses and the stop steps follow each other.
module i2c_unstick_pattern
    import i2c_unstick_pkg::*;
#(
    parameter int N_PULSE = 9,
    parameter int STEP_W  = 5
) (
    input  logic [STEP_W-1:0] step_i,
    output drive_t            drive_o
);
    localparam int PULSE_LO = 3;
    localparam int PULSE_HI = PULSE_LO + 2 * N_PULSE;

    logic [STEP_W-1:0] rel_pulse;
    logic [STEP_W-1:0] rel_stop;

    assign rel_pulse = step_i - STEP_W'(PULSE_LO);
    assign rel_stop  = step_i - STEP_W'(PULSE_HI);

    // map the step to its SCL/SDA drive pair
    always_comb begin
        drive_o = '{scl_low: 1'b0, sda_low: 1'b0};
        if (step_i < STEP_W'(PULSE_LO)) begin
            case (step_i[1:0])
                2'd1:    drive_o = '{scl_low: 1'b0, sda_low: 1'b1};
                2'd2:    drive_o = '{scl_low: 1'b1, sda_low: 1'b1};
                default: drive_o = '{scl_low: 1'b0, sda_low: 1'b0};
            endcase
        end else if (step_i < STEP_W'(PULSE_HI)) begin
            drive_o = '{scl_low: rel_pulse[0], sda_low: 1'b0};
        end else begin
            case (rel_stop[1:0])
                2'd0:    drive_o = '{scl_low: 1'b1, sda_low: 1'b1};
                2'd1:    drive_o = '{scl_low: 1'b0, sda_low: 1'b1};
                default: drive_o = '{scl_low: 1'b0, sda_low: 1'b0};
            endcase
        end
    end
endmodule

// File: rtl/i2c_bus_unstick.sv
// Bus recovery sequencer top. Checks the bus on a transfer request.
// If the bus is stuck, or a timeout is signalled, it takes over the pins,
// plays out the recovery pattern, resets the controller, rechecks the
// lines and reports the result. Assumes external pull-ups on both lines.
module i2c_bus_unstick
    import i2c_unstick_pkg::*;
#(
    parameter int DWELL_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int N_PULSE     = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req_i,
    input  logic               timeout_evt_i,
    input  logic               busy_i,
    input  logic [DWELL_W-1:0] dwell_i,
    input  logic               scl_in_i,
    input  logic               sda_in_i,
    output logic               scl_low_o,
    output logic               sda_low_o,
    output logic               ovr_o,
    output logic               ctl_rst_o,
    output logic               done_o,
    output logic               fail_o,
    output logic [1:0]         cause_o
);
    localparam int NSTEP  = 2 * N_PULSE + 6;
    localparam int STEP_W = $clog2(NSTEP);
    localparam int SET_W  = $clog2(SYNC_STAGES + 2);

    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    logic [SET_W-1:0]  scnt_q;
    cause_e            cause_q;
    logic              done_q, fail_q, crst_q;
    logic [1:0]        lines_s;
    logic              scl_s, sda_s;
    logic              tick;
    logic              bus_idle, trig_tmo, trig_req, launch, fast_ok, running;
    drive_t            drv;

    i2c_unstick_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({scl_in_i, sda_in_i}), .q_o(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    assign running  = (phase_q == PH_RUN);
    assign bus_idle = !busy_i && scl_s && sda_s;
    assign trig_tmo = (phase_q == PH_IDLE) && timeout_evt_i;
    assign trig_req = (phase_q == PH_IDLE) && start_req_i && !timeout_evt_i;
    assign launch   = trig_tmo || (trig_req && !bus_idle);
    assign fast_ok  = trig_req && bus_idle;

    i2c_unstick_dwell #(.W(DWELL_W)) u_dwell (
        .clk(clk), .rst_n(rst_n), .load_i(launch),
        .dwell_i(dwell_i), .run_i(running), .tick_o(tick)
    );

    i2c_unstick_pattern #(.N_PULSE(N_PULSE), .STEP_W(STEP_W)) u_pat (
        .step_i(step_q), .drive_o(drv)
    );

    // phase sequencing, result pulses and cause capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            scnt_q  <= '0;
            cause_q <= CAUSE_NONE;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            crst_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            crst_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (launch) begin
                        phase_q <= PH_RUN;
                        step_q  <= '0;
                        cause_q <= trig_tmo ? CAUSE_TIMEOUT : CAUSE_NOT_IDLE;
                    end else if (fast_ok) begin
                        done_q <= 1'b1;
                    end
                end
                PH_RUN: begin
                    if (tick) begin
                        if (step_q == STEP_W'(NSTEP - 1)) begin
                            phase_q <= PH_SETTLE;
                            scnt_q  <= '0;
                            crst_q  <= 1'b1;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (scnt_q == SET_W'(SYNC_STAGES)) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                        fail_q  <= !(scl_s && sda_s);
                    end else begin
                        scnt_q <= scnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign scl_low_o = running && drv.scl_low;
    assign sda_low_o = running && drv.sda_low;
    assign ovr_o     = running;
    assign ctl_rst_o = crst_q;
    assign done_o    = done_q;
    assign fail_o    = fail_q;
    assign cause_o   = cause_q;
endmodule

// File: rtl/i2c_bus_unstick_chk.sv
// Port-level property checker for the recovery sequencer.
module i2c_bus_unstick_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_low_o,
    input logic       sda_low_o,
    input logic       ovr_o,
    input logic       ctl_rst_o,
    input logic       done_o,
    input logic       fail_o,
    input logic [1:0] cause_o
);
    // R7
    drive_only_in_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_o |-> (!scl_low_o && !sda_low_o));

    // R8
    reset_follows_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_o) |-> ctl_rst_o);

    // R8
    reset_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_o |=> !ctl_rst_o);

    // R8
    reset_outside_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_o |-> !ovr_o);

    // R11
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    // R10
    cause_held_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && $past(ovr_o)) |-> $stable(cause_o));
endmodule

bind i2c_bus_unstick i2c_bus_unstick_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .ovr_o(ovr_o), .ctl_rst_o(ctl_rst_o), .done_o(done_o), .fail_o(fail_o),
    .cause_o(cause_o)
);

// File: tb/i2c_bus_unstick_test.sv
module i2c_bus_unstick_test;
    localparam int SYNC  = 2;
    localparam int NSTEP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req_i = 1'b0, timeout_evt_i = 1'b0, busy_i = 1'b0;
    logic [15:0] dwell_i = '0;
    logic        scl_low_o, sda_low_o, ovr_o, ctl_rst_o, done_o, fail_o;
    logic [1:0]  cause_o;
    int          sda_hold = 0;     // SCL rising edges until the target frees SDA
    logic        scl_stuck = 1'b0;
    int          nchk = 0, nfail = 0;
    wire         scl_line, sda_line;

    assign scl_line = !scl_low_o && !scl_stuck;
    assign sda_line = !sda_low_o && (sda_hold == 0);

    always #5 clk = ~clk;

    always @(posedge scl_line) if (sda_hold > 0) sda_hold = sda_hold - 1;

    i2c_bus_unstick uut (
        .clk(clk), .rst_n(rst_n), .start_req_i(start_req_i),
        .timeout_evt_i(timeout_evt_i), .busy_i(busy_i), .dwell_i(dwell_i),
        .scl_in_i(scl_line), .sda_in_i(sda_line),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .ovr_o(ovr_o),
        .ctl_rst_o(ctl_rst_o), .done_o(done_o), .fail_o(fail_o), .cause_o(cause_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected {scl_low, sda_low} for a step
    function automatic logic [1:0] exp_pair(input int s);
        if (s == 0) return 2'b00;
        if (s == 1) return 2'b01;
        if (s == 2) return 2'b11;
        if (s <= 20) return ((s - 3) % 2 == 0) ? 2'b00 : 2'b10;
        if (s == 21) return 2'b11;
        if (s == 22) return 2'b01;
        return 2'b00;
    endfunction

    task automatic settle_bus();
        sda_hold = 0; scl_stuck = 1'b0; busy_i = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
    endtask

    // kind: 0 request with busy, 1 request with stuck SDA, 2 timeout, 3 both
    task automatic recover(input int kind, input int d, input int hold,
                           input bit stuck_scl, input bit disturb);
        int  first_bad, bad_act, bad_exp, crst_at, done_at, fail_seen;
        bit  exp_fail;
        logic [1:0] exp_cause;
        sda_hold  = hold;
        scl_stuck = stuck_scl;
        repeat (SYNC + 2) @(negedge clk);
        exp_cause = (kind >= 2) ? 2'b10 : 2'b01;
        exp_fail  = stuck_scl || (hold > 10);
        dwell_i = 16'(d);
        busy_i = (kind == 0);
        start_req_i   = (kind != 2);
        timeout_evt_i = (kind >= 2);
        @(negedge clk);
        start_req_i = 1'b0; timeout_evt_i = 1'b0; busy_i = 1'b0;
        // R3 R4: cause at the first override cycle
        check(ovr_o === 1'b1, "R3", "override on next cycle", int'(ovr_o), 1);
        check(cause_o === exp_cause, (kind >= 2) ? "R4" : "R3", "cause code",
              int'(cause_o), int'(exp_cause));
        first_bad = -1; bad_act = 0; bad_exp = 0;
        crst_at = -1; done_at = -1; fail_seen = 0;
        for (int k = 0; k <= NSTEP * (d + 1) + SYNC + 1; k++) begin
            int  step;
            logic [1:0] e;
            step = k / (d + 1);
            if (k < NSTEP * (d + 1)) begin
                e = exp_pair(step);
                if (first_bad < 0 && (ovr_o !== 1'b1 || {scl_low_o, sda_low_o} !== e)) begin
                    first_bad = k; bad_act = {ovr_o, scl_low_o, sda_low_o}; bad_exp = {1'b1, e};
                end
            end else if (first_bad < 0 && (ovr_o !== 1'b0 || scl_low_o || sda_low_o)) begin
                first_bad = k; bad_act = {ovr_o, scl_low_o, sda_low_o}; bad_exp = 0;
            end
            if (ctl_rst_o === 1'b1 && crst_at < 0) crst_at = k;
            if (done_o === 1'b1 && done_at < 0) begin done_at = k; fail_seen = fail_o; end
            if (fail_o === 1'b1 && done_o !== 1'b1) fail_seen = 99;
            if (disturb && k == 5) begin
                start_req_i = 1'b1; timeout_evt_i = 1'b1; busy_i = 1'b1; dwell_i = 16'(d + 3);
            end
            if (disturb && k == 6) begin
                start_req_i = 1'b0; timeout_evt_i = 1'b0; busy_i = 1'b0;
            end
            @(negedge clk);
        end
        // R5 R6 (and R10 when disturbed): per-cycle pattern and step lengths
        check(first_bad < 0, disturb ? "R10" : "R5", "pattern cycle (-1 means none)",
              first_bad, -1);
        if (first_bad >= 0)
            $display("FAIL R6 step content at cycle %0d: actual %0d expected %0d",
                     first_bad, bad_act, bad_exp);
        // R8 controller reset position
        check(crst_at == NSTEP * (d + 1), "R8", "controller reset cycle", crst_at,
              NSTEP * (d + 1));
        // R9 done timing and fail result
        check(done_at == NSTEP * (d + 1) + SYNC + 1, "R9", "done cycle", done_at,
              NSTEP * (d + 1) + SYNC + 1);
        check(fail_seen == int'(exp_fail), "R9", "fail result (R11 pulse rule)",
              fail_seen, int'(exp_fail));
        // R11 done is a single pulse
        check(done_o === 1'b0 && fail_o === 1'b0, "R11", "done/fail cleared",
              {done_o, fail_o}, 0);
        // R10 cause unchanged by later triggers
        check(cause_o === exp_cause, "R10", "cause after run", int'(cause_o),
              int'(exp_cause));
        settle_bus();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({scl_low_o, sda_low_o, ovr_o, ctl_rst_o, done_o, fail_o} === 6'b0,
              "R1", "outputs after reset",
              {scl_low_o, sda_low_o, ovr_o, ctl_rst_o, done_o, fail_o}, 0);
        check(cause_o === 2'b00, "R1", "cause after reset", int'(cause_o), 0);
        settle_bus();

        // R2 fast path on an idle bus
        start_req_i = 1'b1;
        @(negedge clk);
        start_req_i = 1'b0;
        check(done_o === 1'b1 && fail_o === 1'b0, "R2", "fast done/fail",
              {done_o, fail_o}, 2);
        check(ovr_o === 1'b0 && !scl_low_o && !sda_low_o, "R2", "no override (R7)",
              {ovr_o, scl_low_o, sda_low_o}, 0);
        check(cause_o === 2'b00, "R2", "cause untouched", int'(cause_o), 0);
        @(negedge clk);
        check(done_o === 1'b0, "R11", "fast done single pulse", int'(done_o), 0);
        settle_bus();

        // directed corner cases
        recover(0, 0, 0, 1'b0, 1'b0);   // R3 busy, dwell 0
        recover(1, 1, 3, 1'b0, 1'b0);   // R3 SDA stuck, freed early
        recover(2, 2, 0, 1'b0, 1'b0);   // R4 timeout on idle bus
        recover(3, 1, 0, 1'b0, 1'b0);   // R4 timeout wins over request
        recover(1, 0, 10, 1'b0, 1'b0);  // R9 boundary: freed on the stop edge
        recover(1, 0, 11, 1'b0, 1'b0);  // R9 boundary: one edge too many
        recover(2, 1, 1000, 1'b0, 1'b0);// R9 SDA stuck for good
        recover(2, 0, 0, 1'b1, 1'b0);   // R9 SCL stuck for good
        recover(0, 2, 0, 1'b0, 1'b1);   // R10 triggers and dwell change mid-run

        // constrained random
        for (int i = 0; i < 20; i++) begin
            int kind, d, hold;
            kind = $urandom_range(0, 3);
            d    = $urandom_range(0, 4);
            hold = (kind == 1) ? $urandom_range(1, 14) : $urandom_range(0, 1) * $urandom_range(1, 14);
            recover(kind, d, hold, 1'b0, ($urandom_range(0, 3) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule